// File: doc/BRIEF.md
# Gated Reverse Playback Controller

This block steers a stereo sample memory for a triggered reverse effect and advances once per stereo audio frame, on each `frame_strobe` pulse. While idle it records: every frame writes the left sample at one address and the right sample at the next, and live audio passes straight through. The left input is the only one watched. When its level reaches a fixed threshold, the controller marks a buffer floor a fixed distance behind the write pointer. That distance lets the playback catch the start of a note that was already sounding before the threshold was reached.

Recording continues until the write pointer has moved a programmable length beyond the floor. Writing then stops and the frozen buffer is read backwards, two addresses per frame, down to the floor. At the floor, recording resumes and a fade coefficient ramps from full scale down to zero, so an external mixer can blend the reversed audio back into live audio. A holdoff period follows, during which the level detector is ignored. The controller drives addresses, enables, the fade weight and a one-hot phase indication. The memory and the mixing arithmetic sit outside the block.

Top module: `gated_reverse_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the controller in the idle phase, sets the left write address to 1 and the internal read pointer to 0, and makes the fade weight 0.
- R2: On every strobe outside the reverse phase, the left write address advances by 2 modulo 2^18. The right write address is always the left write address plus 1, and `wr_en` is high in every phase except reverse.
- R3: In the idle phase, a strobe arms the controller when the left sample's magnitude is at least 0x3900. A negative sample's magnitude is taken as its bitwise inverse, so 0xC700 does not trigger and 0xC6FF does.
- R4: On arming, the floor is the write address that results from that strobe minus 0x800, modulo 2^18. Armed strobes keep recording. Reverse starts on the strobe whose resulting write address equals floor + (buf_size × 256) modulo 2^18. From then on the write address holds still.
- R5: Reverse starts with the read pointer equal to the write address. In reverse and crossfade, the left read address is pointer − 3 and the right read address is pointer − 2, and each strobe lowers the pointer by 2 modulo 2^18.
- R6: A reverse-phase strobe that finds the pointer equal to the floor enters the crossfade phase with a fade weight of 0xFFFF and re-enables writing. During reverse the fade weight reads 0xFFFF.
- R7: Each crossfade strobe lowers the fade weight by 0x80. The strobe that finds the weight at or below 0x80 moves to holdoff instead. The fade weight is 0 in idle, armed and holdoff.
- R8: Holdoff loads a counter with 0x0F00 and lowers it by 2 per strobe. The strobe that finds it at 2 returns to idle. The threshold has no effect during holdoff.
- R9: Without a strobe, no output changes, whatever the sample and size inputs do.
- R10: `state_onehot` is one-hot, with bit 0 idle, bit 1 armed, bit 2 reverse, bit 3 crossfade and bit 4 holdoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_strobe | input | 1 | One-cycle pulse per stereo frame |
| left_in | input | 16 | Left input sample, two's complement |
| buf_size | input | 16 | Buffer length in units of 256 addresses |
| wr_en | output | 1 | Write the current frame to memory |
| wr_addr_left | output | 18 | Address for the left sample write |
| wr_addr_right | output | 18 | Address for the right sample write |
| rd_en | output | 1 | Reverse data is being read this frame |
| rd_addr_left | output | 18 | Address for the left sample read |
| rd_addr_right | output | 18 | Address for the right sample read |
| fade_coef | output | 16 | Weight of reversed audio in the mix |
| state_onehot | output | 5 | Current phase, one-hot |

## Verification
The properties assume that `frame_strobe` is a single-cycle pulse. They also assume that `buf_size` is steady from arming until reverse starts, and that its scaled length is larger than the backtrack distance, so the armed phase ends in a bounded number of frames. The stimulus sets the size before each trigger and changes it only in idle or holdoff frames. It places strobes every other cycle, with idle gaps in between. The first trigger comes right after reset, so the floor and the reverse read pointer both wrap below address zero.

// File: rtl/grc_pkg.sv
// Shared types for the gated reverse playback controller.
// Assumes: the phase encoding is one-hot and the bit order is fixed.
package grc_pkg;

    // Controller phase, one-hot: idle, armed, reverse, crossfade, holdoff
    typedef enum logic [4:0] {
        PH_IDLE    = 5'b00001,
        PH_ARMED   = 5'b00010,
        PH_REVERSE = 5'b00100,
        PH_FADE    = 5'b01000,
        PH_HOLD    = 5'b10000
    } grc_phase_e;

endpackage

// File: rtl/grc_level_detect.sv
// Level detector for the trigger channel.
// Computes a magnitude by bitwise inversion of negative samples and
// compares it with a fixed threshold. Purely combinational.
// Assumes: the sample is two's complement.
module grc_level_detect #(
    parameter int unsigned SAMPLE_W  = 16,
    parameter int unsigned THRESHOLD = 16'h3900
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic                above
);

    localparam logic [SAMPLE_W-1:0] THRESH_V = SAMPLE_W'(THRESHOLD);

    logic [SAMPLE_W-1:0] magnitude;

    // Ones'-complement magnitude, then the threshold compare
    always_comb begin
        magnitude = sample[SAMPLE_W-1] ? ~sample : sample;
        above     = (magnitude >= THRESH_V);
    end

endmodule

// File: rtl/grc_pointers.sv
// Address pointers of the controller: write pointer, read pointer and
// the buffer floor captured on a trigger.
// Assumes: frame_strobe is a one-cycle pulse and the phase input comes
// from the sequencer in the same clock domain.
module grc_pointers
    import grc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned SIZE_W     = 16,
    parameter int unsigned SIZE_SHIFT = 8,
    parameter int unsigned BACKTRACK  = 16'h0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  grc_phase_e        phase,
    input  logic              level_hit,
    input  logic [SIZE_W-1:0] buf_size,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              reached_top,
    output logic              reached_floor
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] BACK_V = ADDR_W'(BACKTRACK);
    localparam int unsigned       EXT_W  = SIZE_W + SIZE_SHIFT;

    logic [ADDR_W-1:0] floor_q;
    logic [ADDR_W-1:0] wr_next;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] top_addr;
    logic [EXT_W-1:0]  size_ext;

    // Next write pointer, scaled buffer span and the boundary compares
    always_comb begin
        wr_next       = wr_ptr + STEP_V;
        size_ext      = {buf_size, {SIZE_SHIFT{1'b0}}};
        span          = ADDR_W'(size_ext);
        top_addr      = floor_q + span;
        reached_top   = (wr_next == top_addr);
        reached_floor = (rd_ptr == floor_q);
    end

    // Write pointer: advances in every phase but reverse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= ADDR_W'(1);
        end else if (frame_strobe && (phase != PH_REVERSE)) begin
            wr_ptr <= wr_next;
        end
    end

    // Buffer floor: captured a backtrack distance behind on a trigger
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            floor_q <= '0;
        end else if (frame_strobe && (phase == PH_IDLE) && level_hit) begin
            floor_q <= wr_next - BACK_V;
        end
    end

    // Read pointer: loaded at the buffer top, stepped down while reading
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (frame_strobe) begin
            if ((phase == PH_ARMED) && reached_top) begin
                rd_ptr <= wr_next;
            end else if ((phase == PH_REVERSE) || (phase == PH_FADE)) begin
                rd_ptr <= rd_ptr - STEP_V;
            end
        end
    end

endmodule

// File: rtl/grc_sequencer.sv
// Phase sequencer: idle -> armed -> reverse -> crossfade -> holdoff.
// Also owns the fade weight and the holdoff counter.
// Assumes: HOLDOFF is even and non-zero, and FADE_STEP is non-zero.
module grc_sequencer
    import grc_pkg::*;
#(
    parameter int unsigned COEF_W    = 16,
    parameter int unsigned HOLD_W    = 16,
    parameter int unsigned FADE_STEP = 16'h0080,
    parameter int unsigned HOLDOFF   = 16'h0F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic              level_hit,
    input  logic              reached_top,
    input  logic              reached_floor,
    output grc_phase_e        phase,
    output logic [COEF_W-1:0] coef
);

    localparam logic [COEF_W-1:0] STEP_V = COEF_W'(FADE_STEP);
    localparam logic [HOLD_W-1:0] HOLD_V = HOLD_W'(HOLDOFF);
    localparam logic [HOLD_W-1:0] DEC_V  = HOLD_W'(2);

    grc_phase_e        phase_d;
    logic [COEF_W-1:0] coef_d;
    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] hold_d;

    // Next-phase, fade and holdoff decisions for one frame
    always_comb begin
        phase_d = phase;
        coef_d  = coef;
        hold_d  = hold_q;
        unique case (phase)
            PH_IDLE: begin
                if (level_hit) begin
                    phase_d = PH_ARMED;
                end
            end
            PH_ARMED: begin
                if (reached_top) begin
                    phase_d = PH_REVERSE;
                end
            end
            PH_REVERSE: begin
                if (reached_floor) begin
                    phase_d = PH_FADE;
                    coef_d  = '1;
                end
            end
            PH_FADE: begin
                if (coef <= STEP_V) begin
                    phase_d = PH_HOLD;
                    hold_d  = HOLD_V;
                end else begin
                    coef_d  = coef - STEP_V;
                end
            end
            PH_HOLD: begin
                if (hold_q == DEC_V) begin
                    phase_d = PH_IDLE;
                end
                hold_d = hold_q - DEC_V;
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // Register the frame decision on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            coef   <= '0;
            hold_q <= '0;
        end else if (frame_strobe) begin
            phase  <= phase_d;
            coef   <= coef_d;
            hold_q <= hold_d;
        end
    end

endmodule

// File: rtl/gated_reverse_ctrl.sv
// Top of the gated reverse playback controller.
// Links the level detector, the pointer unit and the phase sequencer,
// and forms the memory addresses, enables and the fade weight.
// Assumes: one frame_strobe pulse per stereo frame, and inputs that
// hold steady while the strobe is high.
module gated_reverse_ctrl
    import grc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned SAMPLE_W   = 16,
    parameter int unsigned SIZE_W     = 16,
    parameter int unsigned SIZE_SHIFT = 8,
    parameter int unsigned COEF_W     = 16,
    parameter int unsigned THRESHOLD  = 16'h3900,
    parameter int unsigned BACKTRACK  = 16'h0800,
    parameter int unsigned HOLDOFF    = 16'h0F00,
    parameter int unsigned FADE_STEP  = 16'h0080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_strobe,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SIZE_W-1:0]   buf_size,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr_left,
    output logic [ADDR_W-1:0]   wr_addr_right,
    output logic                rd_en,
    output logic [ADDR_W-1:0]   rd_addr_left,
    output logic [ADDR_W-1:0]   rd_addr_right,
    output logic [COEF_W-1:0]   fade_coef,
    output logic [4:0]          state_onehot
);

    localparam int unsigned HOLD_W = 16;

    logic              level_hit;
    logic              reached_top;
    logic              reached_floor;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [COEF_W-1:0] coef;
    grc_phase_e        phase;

    grc_level_detect #(
        .SAMPLE_W  (SAMPLE_W),
        .THRESHOLD (THRESHOLD)
    ) u_level (
        .sample (left_in),
        .above  (level_hit)
    );

    grc_pointers #(
        .ADDR_W     (ADDR_W),
        .SIZE_W     (SIZE_W),
        .SIZE_SHIFT (SIZE_SHIFT),
        .BACKTRACK  (BACKTRACK)
    ) u_ptrs (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_strobe  (frame_strobe),
        .phase         (phase),
        .level_hit     (level_hit),
        .buf_size      (buf_size),
        .wr_ptr        (wr_ptr),
        .rd_ptr        (rd_ptr),
        .reached_top   (reached_top),
        .reached_floor (reached_floor)
    );

    grc_sequencer #(
        .COEF_W    (COEF_W),
        .HOLD_W    (HOLD_W),
        .FADE_STEP (FADE_STEP),
        .HOLDOFF   (HOLDOFF)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_strobe  (frame_strobe),
        .level_hit     (level_hit),
        .reached_top   (reached_top),
        .reached_floor (reached_floor),
        .phase         (phase),
        .coef          (coef)
    );

    // Memory-side addresses and enables derived from the pointers
    always_comb begin
        wr_en         = (phase != PH_REVERSE);
        wr_addr_left  = wr_ptr;
        wr_addr_right = wr_ptr + ADDR_W'(1);
        rd_en         = (phase == PH_REVERSE) || (phase == PH_FADE);
        rd_addr_left  = rd_ptr - ADDR_W'(3);
        rd_addr_right = rd_ptr - ADDR_W'(2);
        state_onehot  = phase;
    end

    // Mix weight of reversed audio for the current phase
    always_comb begin
        if (phase == PH_REVERSE) begin
            fade_coef = '1;
        end else if (phase == PH_FADE) begin
            fade_coef = coef;
        end else begin
            fade_coef = '0;
        end
    end

endmodule

// File: rtl/grc_checker.sv
// Temporal checks on the controller's ports, attached through bind.
// Assumes: frame_strobe is a single-cycle pulse.
module grc_checker #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned COEF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_strobe,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr_left,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr_left,
    input logic [COEF_W-1:0] fade_coef,
    input logic [4:0]        state_onehot
);

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_onehot)); // R10

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && wr_en) |=> (wr_addr_left == $past(wr_addr_left) + ADDR_W'(2))); // R2

    AST_WR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && state_onehot[2]) |=> $stable(wr_addr_left)); // R4

    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && rd_en) |=> (rd_addr_left == $past(rd_addr_left) - ADDR_W'(2))); // R5

    AST_FADE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && state_onehot[2]) |=> (state_onehot[2] || (state_onehot[3] && fade_coef == '1))); // R6

    AST_FADE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && state_onehot[3]) |=> (state_onehot[3] || (state_onehot[4] && fade_coef == '0))); // R7

    AST_HOLD_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && state_onehot[4]) |=> (state_onehot[4] || state_onehot[0])); // R8

    AST_NO_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> ($stable(state_onehot) && $stable(wr_addr_left) && $stable(rd_addr_left))); // R9

endmodule

bind gated_reverse_ctrl grc_checker #(
    .ADDR_W (ADDR_W),
    .COEF_W (COEF_W)
) u_grc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .wr_en        (wr_en),
    .wr_addr_left (wr_addr_left),
    .rd_en        (rd_en),
    .rd_addr_left (rd_addr_left),
    .fade_coef    (fade_coef),
    .state_onehot (state_onehot)
);

// File: tb/gated_reverse_ctrl_tb.sv
// Bench: behavioural frame model compared with the outputs on every clock.
module gated_reverse_ctrl_tb;

    localparam int MASK = 32'h3FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_strobe = 1'b0;
    logic [15:0] left_in = '0;
    logic [15:0] buf_size = 16'h000C;
    logic        wr_en;
    logic [17:0] wr_addr_left;
    logic [17:0] wr_addr_right;
    logic        rd_en;
    logic [17:0] rd_addr_left;
    logic [17:0] rd_addr_right;
    logic [15:0] fade_coef;
    logic [4:0]  state_onehot;

    int errors = 0;
    int checks = 0;
    bit model_on = 1'b0;

    // model state: 0 idle, 1 armed, 2 reverse, 3 crossfade, 4 holdoff
    int m_st, m_wr, m_rd, m_bot, m_coef, m_hold;

    always #5 clk = ~clk;

    gated_reverse_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_strobe  (frame_strobe),
        .left_in       (left_in),
        .buf_size      (buf_size),
        .wr_en         (wr_en),
        .wr_addr_left  (wr_addr_left),
        .wr_addr_right (wr_addr_right),
        .rd_en         (rd_en),
        .rd_addr_left  (rd_addr_left),
        .rd_addr_right (rd_addr_right),
        .fade_coef     (fade_coef),
        .state_onehot  (state_onehot)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string phase_tag();
        case (m_st)
            0: return "R3";
            1: return "R4";
            2: return "R6";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compare_all();
        check(phase_tag(), int'(state_onehot), 1 << m_st);              // R10
        check("R2", int'(wr_en), (m_st != 2) ? 1 : 0);
        check("R2", int'(wr_addr_left), m_wr);
        check("R2", int'(wr_addr_right), (m_wr + 1) & MASK);
        check("R5", int'(rd_en), (m_st == 2 || m_st == 3) ? 1 : 0);
        check("R5", int'(rd_addr_left), (m_rd - 3) & MASK);
        check("R5", int'(rd_addr_right), (m_rd - 2) & MASK);
        check("R7", int'(fade_coef), (m_st == 2) ? 32'hFFFF : (m_st == 3) ? m_coef : 0);
    endtask

    // Behavioural frame step from the requirements
    task automatic model_step(input logic [15:0] s, input int size);
        logic [15:0] mag;
        mag = s[15] ? ~s : s;
        case (m_st)
            0: begin
                m_wr = (m_wr + 2) & MASK;
                if (mag >= 16'h3900) begin
                    m_bot = (m_wr - 32'h800) & MASK;
                    m_st = 1;
                end
            end
            1: begin
                m_wr = (m_wr + 2) & MASK;
                if (m_wr == ((m_bot + (size << 8)) & MASK)) begin
                    m_rd = m_wr;
                    m_st = 2;
                end
            end
            2: begin
                if (m_rd == m_bot) begin
                    m_st = 3;
                    m_coef = 32'hFFFF;
                end
                m_rd = (m_rd - 2) & MASK;
            end
            3: begin
                m_wr = (m_wr + 2) & MASK;
                m_rd = (m_rd - 2) & MASK;
                if (m_coef <= 32'h80) begin
                    m_st = 4;
                    m_hold = 32'hF00;
                end else begin
                    m_coef = m_coef - 32'h80;
                end
            end
            default: begin
                m_wr = (m_wr + 2) & MASK;
                if (m_hold == 2) m_st = 0;
                m_hold = m_hold - 2;
            end
        endcase
    endtask

    // Per-clock comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (model_on) compare_all();
    end

    task automatic frame(input logic [15:0] s);
        @(posedge clk);
        #1;
        left_in = s;
        frame_strobe = 1'b1;
        @(posedge clk);
        #1;
        frame_strobe = 1'b0;
        model_step(s, int'(buf_size));
    endtask

    task automatic frames_until(input int st, input logic [15:0] s, input int limit);
        for (int i = 0; i < limit && m_st != st; i++) frame(s);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_st = 0; m_wr = 1; m_rd = 0; m_bot = 0; m_coef = 0; m_hold = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", int'(state_onehot), 1);
        check("R1", int'(wr_addr_left), 1);
        check("R1", int'(rd_addr_left), (0 - 3) & MASK);
        check("R1", int'(fade_coef), 0);
        model_on = 1'b1;

        // R2 and R3: quiet frames plus near-threshold values that must not trigger
        frame(16'h0100);
        frame(16'h38FF);
        frame(16'hC700);   // inverse 0x38FF
        frame(16'h8000);   // inverse 0x7FFF would trigger; kept for later
        // the frame above triggers (magnitude 0x7FFF): floor wraps below zero
        @(negedge clk);
        check("R3", int'(state_onehot), 2);

        // R9: no strobe, loud input, outputs hold
        left_in = 16'h7FFF;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R9", int'(state_onehot), 2);
        check("R9", int'(wr_addr_left), m_wr);

        // R4 to R8: full cycle at size 0x0C, loud input during holdoff
        frames_until(2, 16'h0010, 2000);
        check("R4", m_st, 2);
        frame(16'h7FFF);
        frames_until(3, 16'h0000, 4000);
        check("R6", m_st, 3);
        frames_until(4, 16'h0000, 1000);
        check("R7", m_st, 4);
        frame(16'h7FFF);
        frame(16'hC6FF);
        @(negedge clk);
        check("R8", int'(state_onehot), 16);
        frames_until(0, 16'h7FFF, 3000);
        check("R8", m_st, 0);

        // second trigger: negative sample at the limit, new size
        buf_size = 16'h0010;
        frame(16'h0000);
        frame(16'hC6FF);
        check("R3", m_st, 1);
        frames_until(0, 16'h0200, 8000);
        check("R8", m_st, 0);

        @(negedge clk);
        model_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule